// File: doc/BRIEF.md
# Pipelined Signed Shift-Add Multiplier

The block forms the product of two 8-bit two's complement operands with a chain of registered shift-and-add stages. A first stage loads the operands and seeds the running sum; each following stage folds in one lower bit of operand B. Every stage keeps its own copy of the partial sum, the aligned A operand, the unconsumed B bits and a valid bit. Because of this, a fresh operand pair may enter on every clock while older pairs are still moving down the chain.

The top bit of B carries a weight of -128. It is handled in the load stage: the running sum starts from the negation of A shifted up by seven places instead of from zero. The product bus is 15 bits wide and is read as a two's complement value. The single input that does not fit, -128 times -128, wraps modulo 2^15. A valid flag travels with the data, so each finished product is marked by a one-cycle output strobe at a fixed latency.

Top module: `shift_add_mul_pipe`

## Requirements
- R1: product_o equals a_i times b_i, with both operands taken as 8-bit two's complement values, reduced modulo 2^15 and presented as a 15-bit two's complement value.
- R2: Operands sampled on rising edge n appear on product_o, with out_valid_o high, in the cycle between rising edges n+7 and n+8. This is a latency of eight register stages.
- R3: out_valid_o is high for exactly one cycle for each accepted operand pair and is never high otherwise.
- R4: A new pair can be accepted on every clock. Pairs accepted on consecutive edges produce results on consecutive cycles, in the order in which they were accepted.
- R5: While in_valid_i is low, a_i and b_i are ignored and produce no result.
- R6: While out_valid_o is low, product_o keeps the most recent product. This value is zero after reset.
- R7: A set bit 7 of b_i weighs -128: for example, 5 times -128 gives 15'h7D80, and -1 times -1 gives 1.
- R8: -128 times -128 wraps to 15'h4000, and -128 times 127 gives 15'h4080.
- R9: Driving rst_ni low clears out_valid_o and product_o to zero at once, without waiting for a clock, and discards every pair in flight.
- R10: A zero on either operand gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Qualifies a_i and b_i in this cycle |
| a_i | input | 8 | Multiplicand, two's complement |
| b_i | input | 8 | Multiplier, two's complement |
| out_valid_o | output | 1 | Marks a finished product for one cycle |
| product_o | output | 15 | Product, two's complement |

## Verification
The assertions assume that in_valid_i, a_i and b_i are never unknown once reset is released. They also assume that rst_ni is low across at least one rising edge before traffic starts, so that the in-flight count begins at zero. The stimulus drives every input to a known value on falling edges only, including the don't-care operands used during gaps. It asserts reset away from the rising edge, so no stage ever loads an undefined operand.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
  localparam int unsigned DEF_A_W = 8;
  localparam int unsigned DEF_B_W = 8;
endpackage

// File: rtl/mul_load_stage.sv
module mul_load_stage #(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 8,
  parameter int unsigned P_W = A_W + B_W - 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           vld_o,
  output logic [P_W-1:0] sum_o,
  output logic [P_W-1:0] a_sh_o,
  output logic [B_W-2:0] b_rem_o
);
  logic [P_W-1:0] a_ext;
  logic [P_W-1:0] neg_top;

  assign a_ext   = {{(P_W-A_W){a_i[A_W-1]}}, a_i};
  // B sign bit carries weight -2^(B_W-1): seed with -(A << (B_W-1))
  assign neg_top = '0 - (a_ext << (B_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      sum_o   <= '0;
      a_sh_o  <= '0;
      b_rem_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        sum_o   <= b_i[B_W-1] ? neg_top : '0;
        a_sh_o  <= a_ext;
        b_rem_o <= b_i[B_W-2:0];
      end
    end
  end

  a_r7_pos_b_zero_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !b_i[B_W-1] |=> sum_o == '0);

  a_r7_neg_b_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && b_i[B_W-1] |=> (sum_o + ($past(a_ext) << (B_W-1))) == '0);
endmodule

// File: rtl/mul_add_stage.sv
module mul_add_stage #(
  parameter int unsigned P_W = 15,
  parameter int unsigned R_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  logic [P_W-1:0] sum_i,
  input  logic [P_W-1:0] a_sh_i,
  input  logic [R_W-1:0] b_rem_i,
  output logic           vld_o,
  output logic [P_W-1:0] sum_o,
  output logic [P_W-1:0] a_sh_o,
  output logic [R_W-1:0] b_rem_o
);
  logic [P_W-1:0] addend;

  assign addend = b_rem_i[0] ? a_sh_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      sum_o   <= '0;
      a_sh_o  <= '0;
      b_rem_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        sum_o   <= sum_i + addend;
        a_sh_o  <= a_sh_i << 1;
        b_rem_o <= b_rem_i >> 1;
      end
    end
  end

  a_r1_clear_bit_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !b_rem_i[0] |=> sum_o == $past(sum_i));

  a_r6_idle_holds_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(sum_o));
endmodule

// File: rtl/shift_add_mul_pipe.sv
module shift_add_mul_pipe
  import shift_add_mul_pkg::*;
#(
  parameter int unsigned A_W = DEF_A_W,
  parameter int unsigned B_W = DEF_B_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  input  logic [A_W-1:0]         a_i,
  input  logic [B_W-1:0]         b_i,
  output logic                   out_valid_o,
  output logic [A_W+B_W-2:0]     product_o
);
  localparam int unsigned P_W     = A_W + B_W - 1;
  localparam int unsigned N_ADD   = B_W - 1;
  localparam int unsigned LATENCY = N_ADD + 1;
  localparam int unsigned CNT_W   = $clog2(LATENCY + 1) + 1;

  logic           vld_s  [N_ADD+1];
  logic [P_W-1:0] sum_s  [N_ADD+1];
  logic [P_W-1:0] ash_s  [N_ADD+1];
  logic [N_ADD-1:0] brem_s [N_ADD+1];

  mul_load_stage #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) i_load (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (in_valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .vld_o   (vld_s[0]),
    .sum_o   (sum_s[0]),
    .a_sh_o  (ash_s[0]),
    .b_rem_o (brem_s[0])
  );

  for (genvar k = 0; k < N_ADD; k++) begin : g_add
    mul_add_stage #(.P_W(P_W), .R_W(N_ADD)) i_add (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .vld_i   (vld_s[k]),
      .sum_i   (sum_s[k]),
      .a_sh_i  (ash_s[k]),
      .b_rem_i (brem_s[k]),
      .vld_o   (vld_s[k+1]),
      .sum_o   (sum_s[k+1]),
      .a_sh_o  (ash_s[k+1]),
      .b_rem_o (brem_s[k+1])
    );
  end

  assign out_valid_o = vld_s[N_ADD];
  assign product_o   = sum_s[N_ADD];

  // in-flight count for checking only
  logic [CNT_W-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CNT_W'(in_valid_i) - CNT_W'(out_valid_o);
  end

  a_r3_no_orphan_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> inflight_q != '0);

  a_r4_inflight_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CNT_W'(LATENCY));

  a_r1_all_bits_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_s[N_ADD] |-> brem_s[N_ADD] == '0 && ash_s[N_ADD][N_ADD-1:0] == '0);

  a_r9_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |-> !out_valid_o && product_o == '0);
endmodule

// File: tb/test_shift_add_mul_pipe.sv
`timescale 1ns/1ps
module test_shift_add_mul_pipe;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  a_in = '0;
  logic [7:0]  b_in = '0;
  logic        out_valid;
  logic [14:0] product;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  logic        dl_v [LAT];
  logic [14:0] dl_p [LAT];
  string       dl_t [LAT];
  logic [14:0] last_prod;
  logic        obs_vld;

  always #2.5 clk = ~clk;

  shift_add_mul_pipe i_shift_add_mul_pipe (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .a_i         (a_in),
    .b_i         (b_in),
    .out_valid_o (out_valid),
    .product_o   (product)
  );

  function automatic logic [14:0] ref_mul(input logic signed [7:0] a, input logic signed [7:0] b);
    logic signed [15:0] full;
    full = 16'(a) * 16'(b);
    full = a * b;
    return full[14:0];
  endfunction

  task automatic fail(input string tag, input logic [15:0] act, input logic [15:0] exp);
    errs++;
    $display("FAIL %s: actual %h expected %h", tag, act, exp);
  endtask

  task automatic clear_line();
    for (int i = 0; i < LAT; i++) begin
      dl_v[i] = 1'b0; dl_p[i] = '0; dl_t[i] = "idle";
    end
    last_prod = '0;
  endtask

  // observe what the pair from LAT pushes ago produced, then drive a new cycle
  task automatic push(input logic v, input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    obs_vld = out_valid;
    checks++;
    if (out_valid !== dl_v[LAT-1])
      fail({"R3 out_valid ", dl_t[LAT-1]}, {15'd0, out_valid}, {15'd0, dl_v[LAT-1]});
    else if (dl_v[LAT-1]) begin
      checks++;
      if (product !== dl_p[LAT-1]) fail(dl_t[LAT-1], {1'b0, product}, {1'b0, dl_p[LAT-1]});
      last_prod = dl_p[LAT-1];
    end else begin
      checks++;
      if (product !== last_prod) fail("R6 hold", {1'b0, product}, {1'b0, last_prod});
    end
    for (int i = LAT-1; i > 0; i--) begin
      dl_v[i] = dl_v[i-1]; dl_p[i] = dl_p[i-1]; dl_t[i] = dl_t[i-1];
    end
    dl_v[0] = v; dl_p[0] = ref_mul(a, b); dl_t[0] = tag;
    in_valid = v; a_in = a; b_in = b;
  endtask

  task automatic flush();
    for (int i = 0; i < LAT + 1; i++) push(1'b0, 8'($urandom), 8'($urandom), "idle");
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || product !== '0)
      fail("R9 reset state", {out_valid, product}, 16'd0);
  endtask

  task automatic t_corners();
    push(1'b1, 8'h80, 8'h80, "R8 -128*-128");
    push(1'b1, 8'h80, 8'h7F, "R8 -128*127");
    push(1'b1, 8'h7F, 8'h80, "R8 127*-128");
    push(1'b1, 8'h05, 8'h80, "R7 5*-128");
    push(1'b1, 8'hFF, 8'hFF, "R7 -1*-1");
    push(1'b1, 8'h00, 8'h80, "R10 0*-128");
    push(1'b1, 8'h93, 8'h00, "R10 x*0");
    push(1'b1, 8'h7F, 8'h7F, "R1 127*127");
    push(1'b1, 8'hFF, 8'h01, "R1 -1*1");
    flush();
    checks++;
    if (ref_mul(8'h80, 8'h80) !== 15'h4000) fail("R8 reference", {1'b0, ref_mul(8'h80, 8'h80)}, 16'h4000);
  endtask

  task automatic t_latency();
    int seen;
    seen = -1;
    push(1'b1, 8'h0B, 8'hF3, "R2 single");
    for (int i = 1; i <= LAT + 2; i++) begin
      push(1'b0, 8'hAA, 8'h55, "idle");
      if (obs_vld === 1'b1 && seen < 0) seen = i;
    end
    checks++;
    if (seen != LAT) fail("R2 latency", 16'(seen), 16'(LAT));
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 40; i++) push(1'b1, 8'($urandom), 8'($urandom), "R4 back-to-back");
    flush();
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 300; i++) begin
      logic v;
      v = ($urandom_range(0, 2) != 0);
      push(v, 8'($urandom), 8'($urandom), v ? "R1 random" : "R5 ignored");
    end
    flush();
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 4; i++) push(1'b1, 8'(i + 3), 8'h81, "R9 discarded");
    #1 rst_ni = 1'b0;
    #0.5;
    checks++;
    if (out_valid !== 1'b0 || product !== '0) fail("R9 async clear", {out_valid, product}, 16'd0);
    in_valid = 1'b0;
    clear_line();
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    flush();
  endtask

  initial begin
    clear_line();
    #1 rst_ni = 1'b0;
    #10 t_reset_state();
    rst_ni = 1'b1;
    t_corners();
    t_latency();
    t_back_to_back();
    t_gaps();
    t_reset_mid();
    t_corners();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule